// File: doc/BRIEF.md
# BCD Calendar Counter with Century Flag

This block holds the time of day and the calendar date as packed BCD fields: seconds, minutes, hours (24-hour form), day of week, day of month, month and two-digit year. A century flag with its own enable sits alongside them. On every cycle where the one-per-second `tick` input is high, the clock advances by one second. The carries ripple through every field inside the same clock cycle, so the parallel outputs never show a mix of old and new values.

A host loads any single field through a select/data write port. A loaded value that is not a legal BCD value is kept. It is then counted on from where it stands until the field wraps, and from that point the field holds legal values again. Month lengths follow the calendar. February gets 29 days in any year whose two-digit value is a multiple of four. Each write also sends a one-cycle pulse that tells the external tick generator to restart its sub-second prescaler. Tick generation and the host bus are outside this block.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the outputs are: seconds 00, minutes 00, hours 00, day of week 1, date 01, month 01, year RST_YEAR, century 0, century enable RST_CENT_EN. `prescClr` is 0.
- R2: On a tick, seconds count 00..59 and minutes count 00..59, each wrapping to 00 and carrying into the next field. Hours count 00..23 and wrap to 00, carrying into the day. A single tick at 23:59:59 changes every affected field together.
- R3: Day of week counts 1..7 and wraps from 7 to 1 on the day carry. A stored value of 0 advances to 1.
- R4: Date wraps to 01 and carries into the month after 30 in months 04, 06, 09 and 11. In every other month value, including invalid ones, it wraps after 31. Months count 01..12 and wrap to 01, carrying into the year.
- R5: In month 02 the date wraps after 29 when the year is a multiple of four (BCD units 0/4/8 with even tens, or 2/6 with odd tens). Otherwise it wraps after 28.
- R6: The year counts 00..99 and wraps to 00 when December 31 ends.
- R7: On the year wrap, the century flag toggles when century enable is 1. It keeps its value when century enable is 0.
- R8: A field that holds a value above its maximum advances by BCD step: the units digit goes up, and a units digit of 9 or more clears it and raises the tens digit. The field wraps to its minimum, with a carry, on the first tick that finds its units digit at 9 or more. A value at or below the maximum follows the normal rules.
- R9: When `wrEn` is 1, the field picked by `wrSel` takes `wrData` on the next edge. A tick in that same cycle is dropped and no field advances. The encoding is 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 century control (bit 0 century, bit 1 enable).
- R10: `prescClr` is 1 for exactly the cycle that follows each write cycle. It is 0 otherwise.
- R11: With neither tick nor write, no output changes.
- R12: Data bits above a field's width are ignored on a write: hours take `wrData[5:0]`, seconds take `wrData[6:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance strobe |
| wrEn | input | 1 | Host write strobe |
| wrSel | input | 3 | Field select for the write |
| wrData | input | 8 | Write value |
| secOut | output | 7 | Seconds, BCD |
| minOut | output | 7 | Minutes, BCD |
| hourOut | output | 6 | Hours, 24-hour BCD |
| dowOut | output | 3 | Day of week, 1 = Sunday |
| dateOut | output | 6 | Day of month, BCD |
| monthOut | output | 5 | Month, BCD |
| yearOut | output | 8 | Two-digit year, BCD |
| centOut | output | 1 | Century flag |
| centEnOut | output | 1 | Century toggling enabled |
| prescClr | output | 1 | Prescaler restart pulse after a write |

## Verification
The bench builds the block with RST_YEAR = 8'h24 and RST_CENT_EN = 1. The non-zero reset year makes the reset check able to tell the parameter apart from a hard-wired zero. It also shows that the enable comes from the parameter and not from a constant. All other states are reached by writing fields before each tick. That puts every month-end, the leap and common February cases, the year wrap with the enable set and with it clear, and the out-of-range values within a single tick of the event under test.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int unsigned FIELD_CNT = 8;
  localparam int unsigned SEL_W = $clog2(FIELD_CNT);

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_DOW   = 3'd3,
    SEL_DATE  = 3'd4,
    SEL_MONTH = 3'd5,
    SEL_YEAR  = 3'd6,
    SEL_CENT  = 3'd7
  } fieldSel_e;

  // advance strobes from control to datapath
  typedef struct packed {
    logic advSec;
    logic advMin;
    logic advHour;
    logic advDay;
    logic advMonth;
    logic advYear;
    logic flipCent;
  } calStrobes_t;

  // wrap status from datapath to control
  typedef struct packed {
    logic secWrap;
    logic minWrap;
    logic hourWrap;
    logic dateWrap;
    logic monthWrap;
    logic yearWrap;
    logic centEn;
  } calWraps_t;

  // multiple of four on a packed BCD year
  function automatic logic isLeap(input logic [7:0] year);
    logic [3:0] u;
    u = year[3:0];
    if (year[4]) return (u == 4'd2) || (u == 4'd6);
    else         return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
  endfunction

  // last date of the month in BCD
  function automatic logic [5:0] monthLast(input logic [4:0] month,
                                           input logic [7:0] year);
    case (month)
      5'h02:                      return isLeap(year) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_field.sv
// One BCD counting field: next value and wrap flag from its current value.
module cal_field #(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] maxV,
  input  logic [W-1:0] minV,
  output logic         wrap,
  output logic [W-1:0] next
);

  logic         unitsFull;
  logic [W-1:0] carryVal;

  generate
    if (W > 4) begin : g_bcd
      assign unitsFull = cur[3:0] >= 4'd9;
      assign carryVal  = {cur[W-1:4] + 1'b1, 4'h0};
    end else begin : g_bin
      assign unitsFull = 1'b0;
      assign carryVal  = '0;
    end
  endgenerate

  always_comb begin
    wrap = (cur == maxV) || ((cur > maxV) && unitsFull);
    if (wrap)           next = minV;
    else if (unitsFull) next = carryVal;
    else                next = cur + 1'b1;
  end

endmodule

// File: rtl/cal_ctrl.sv
// Turns tick, write and wrap status into per-field strobes.
module cal_ctrl
  import cal_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 wrEn,
  input  logic [SEL_W-1:0]     wrSel,
  input  calWraps_t            wraps,
  output calStrobes_t          stb,
  output logic [FIELD_CNT-1:0] loadMask,
  output logic                 prescClr
);

  logic advance;

  // a write owns the cycle; the tick is dropped
  assign advance = tick && !wrEn;

  always_comb begin
    stb.advSec   = advance;
    stb.advMin   = stb.advSec   && wraps.secWrap;
    stb.advHour  = stb.advMin   && wraps.minWrap;
    stb.advDay   = stb.advHour  && wraps.hourWrap;
    stb.advMonth = stb.advDay   && wraps.dateWrap;
    stb.advYear  = stb.advMonth && wraps.monthWrap;
    stb.flipCent = stb.advYear  && wraps.yearWrap && wraps.centEn;
  end

  always_comb begin
    for (int i = 0; i < FIELD_CNT; i++) begin
      loadMask[i] = wrEn && (wrSel == SEL_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) prescClr <= 1'b0;
    else       prescClr <= wrEn;
  end

endmodule

// File: rtl/cal_datapath.sv
// Field registers, their step logic and the month-length decode.
module cal_datapath
  import cal_pkg::*;
#(
  parameter logic [7:0] RST_YEAR    = 8'h00,
  parameter bit         RST_CENT_EN = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  calStrobes_t          stb,
  input  logic [FIELD_CNT-1:0] loadMask,
  input  logic [7:0]           wrData,
  output calWraps_t            wraps,
  output logic [6:0]           secQ,
  output logic [6:0]           minQ,
  output logic [5:0]           hourQ,
  output logic [2:0]           dowQ,
  output logic [5:0]           dateQ,
  output logic [4:0]           monthQ,
  output logic [7:0]           yearQ,
  output logic                 centQ,
  output logic                 centEnQ
);

  logic [6:0] secNext, minNext;
  logic [5:0] hourNext, dateNext, dateMax;
  logic [2:0] dowNext;
  logic [4:0] monthNext;
  logic [7:0] yearNext;
  logic       secW, minW, hourW, dowW, dateW, monthW, yearW;

  assign dateMax = monthLast(monthQ, yearQ);

  cal_field #(.W(7)) i_sec   (.cur(secQ),   .maxV(7'h59), .minV(7'h00),
                              .wrap(secW),   .next(secNext));
  cal_field #(.W(7)) i_min   (.cur(minQ),   .maxV(7'h59), .minV(7'h00),
                              .wrap(minW),   .next(minNext));
  cal_field #(.W(6)) i_hour  (.cur(hourQ),  .maxV(6'h23), .minV(6'h00),
                              .wrap(hourW),  .next(hourNext));
  cal_field #(.W(3)) i_dow   (.cur(dowQ),   .maxV(3'd7),  .minV(3'd1),
                              .wrap(dowW),   .next(dowNext));
  cal_field #(.W(6)) i_date  (.cur(dateQ),  .maxV(dateMax), .minV(6'h01),
                              .wrap(dateW),  .next(dateNext));
  cal_field #(.W(5)) i_month (.cur(monthQ), .maxV(5'h12), .minV(5'h01),
                              .wrap(monthW), .next(monthNext));
  cal_field #(.W(8)) i_year  (.cur(yearQ),  .maxV(8'h99), .minV(8'h00),
                              .wrap(yearW),  .next(yearNext));

  always_comb begin
    wraps.secWrap   = secW;
    wraps.minWrap   = minW;
    wraps.hourWrap  = hourW;
    wraps.dateWrap  = dateW;
    wraps.monthWrap = monthW;
    wraps.yearWrap  = yearW;
    wraps.centEn    = centEnQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ    <= 7'h00;
      minQ    <= 7'h00;
      hourQ   <= 6'h00;
      dowQ    <= 3'd1;
      dateQ   <= 6'h01;
      monthQ  <= 5'h01;
      yearQ   <= RST_YEAR;
      centQ   <= 1'b0;
      centEnQ <= RST_CENT_EN;
    end else begin
      if (loadMask[SEL_SEC])       secQ <= wrData[6:0];
      else if (stb.advSec)         secQ <= secNext;

      if (loadMask[SEL_MIN])       minQ <= wrData[6:0];
      else if (stb.advMin)         minQ <= minNext;

      if (loadMask[SEL_HOUR])      hourQ <= wrData[5:0];
      else if (stb.advHour)        hourQ <= hourNext;

      if (loadMask[SEL_DOW])       dowQ <= wrData[2:0];
      else if (stb.advDay)         dowQ <= dowNext;

      if (loadMask[SEL_DATE])      dateQ <= wrData[5:0];
      else if (stb.advDay)         dateQ <= dateNext;

      if (loadMask[SEL_MONTH])     monthQ <= wrData[4:0];
      else if (stb.advMonth)       monthQ <= monthNext;

      if (loadMask[SEL_YEAR])      yearQ <= wrData;
      else if (stb.advYear)        yearQ <= yearNext;

      if (loadMask[SEL_CENT]) begin
        centQ   <= wrData[0];
        centEnQ <= wrData[1];
      end else if (stb.flipCent) begin
        centQ   <= ~centQ;
      end
    end
  end

  // the day-of-week wrap is not a carry source
  logic unusedDowW;
  assign unusedDowW = dowW;

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter logic [7:0] RST_YEAR    = 8'h00,
  parameter bit         RST_CENT_EN = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  input  logic [7:0] wrData,
  output logic [6:0] secOut,
  output logic [6:0] minOut,
  output logic [5:0] hourOut,
  output logic [2:0] dowOut,
  output logic [5:0] dateOut,
  output logic [4:0] monthOut,
  output logic [7:0] yearOut,
  output logic       centOut,
  output logic       centEnOut,
  output logic       prescClr
);

  calStrobes_t          stb;
  calWraps_t            wraps;
  logic [FIELD_CNT-1:0] loadMask;

  cal_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wraps    (wraps),
    .stb      (stb),
    .loadMask (loadMask),
    .prescClr (prescClr)
  );

  cal_datapath #(
    .RST_YEAR    (RST_YEAR),
    .RST_CENT_EN (RST_CENT_EN)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .loadMask (loadMask),
    .wrData   (wrData),
    .wraps    (wraps),
    .secQ     (secOut),
    .minQ     (minOut),
    .hourQ    (hourOut),
    .dowQ     (dowOut),
    .dateQ    (dateOut),
    .monthQ   (monthOut),
    .yearQ    (yearOut),
    .centQ    (centOut),
    .centEnQ  (centEnOut)
  );

endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic       wrEn,
  input logic [2:0] wrSel,
  input logic [7:0] wrData,
  input logic [6:0] secOut,
  input logic [6:0] minOut,
  input logic [5:0] hourOut,
  input logic [2:0] dowOut,
  input logic [5:0] dateOut,
  input logic [4:0] monthOut,
  input logic [7:0] yearOut,
  input logic       centOut,
  input logic       centEnOut,
  input logic       prescClr
);

  logic [44:0] allFields;
  assign allFields = {secOut, minOut, hourOut, dowOut, dateOut, monthOut,
                      yearOut, centOut, centEnOut};

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !wrEn) |=> $stable(allFields)); // R11

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !wrEn && secOut == 7'h59) |=> (secOut == 7'h00)); // R2

  AST_MIN_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !wrEn && secOut == 7'h30) |=> $stable(minOut)); // R2

  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !wrEn && dowOut == 3'd7 && secOut == 7'h59 &&
     minOut == 7'h59 && hourOut == 6'h23) |=> (dowOut == 3'd1)); // R3

  AST_CENT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!centEnOut && !wrEn) |=> $stable(centOut)); // R7

  AST_WR_LOAD_SEC: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 3'd0) |=> (secOut == $past(wrData[6:0]))); // R9

  AST_WR_DROPS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel != 3'd0) |=> $stable(secOut)); // R9

  AST_PRESC_AFTER_WR: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> prescClr); // R10

  AST_PRESC_ONLY_WR: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !prescClr); // R10

endmodule

bind bcd_calendar cal_checker i_cal_checker (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .wrEn      (wrEn),
  .wrSel     (wrSel),
  .wrData    (wrData),
  .secOut    (secOut),
  .minOut    (minOut),
  .hourOut   (hourOut),
  .dowOut    (dowOut),
  .dateOut   (dateOut),
  .monthOut  (monthOut),
  .yearOut   (yearOut),
  .centOut   (centOut),
  .centEnOut (centEnOut),
  .prescClr  (prescClr)
);

// File: tb/test_bcd_calendar.sv
`timescale 1ns/1ps
module test_bcd_calendar;

  localparam realtime CLK_HALF = 4.0;
  localparam int      NVEC = 21;

  // each entry: start {sec,min,hour,dow,date,month,year,ctl} then expected
  localparam logic [127:0] VEC [NVEC] = '{
    128'h00000003_15062400_01000003_15062400, // R2 plain second
    128'h59341203_15062400_00351203_15062400, // R2 minute carry
    128'h59592307_30042300_00000001_01052300, // R2 R3 R4 April end
    128'h59592302_30052300_00000003_31052300, // R4 May has 31
    128'h59592305_31012300_00000006_01022300, // R4 January end
    128'h59592301_28022400_00000002_29022400, // R5 leap Feb 28
    128'h59592301_28022300_00000002_01032300, // R5 common Feb 28
    128'h59592304_29022400_00000005_01032400, // R5 leap Feb 29
    128'h59592306_31129903_00000007_01010002, // R6 R7 wrap, enabled
    128'h59592306_31129901_00000007_01010001, // R6 R7 wrap, disabled
    128'h65100503_15062400_66100503_15062400, // R8 seconds above max
    128'h69100503_15062400_00110503_15062400, // R8 units 9 wraps
    128'h59592703_15062400_00002803_15062400, // R8 hours above max
    128'h59592300_15062400_00000001_16062400, // R3 day of week zero
    128'h59592303_28021200_00000004_29021200, // R5 year 12 leap
    128'h59592303_31132400_00000004_01142400, // R4 R8 invalid month
    128'h59592303_30092400_00000004_01102400, // R4 September
    128'h59592303_30112400_00000004_01122400, // R4 November
    128'h59592303_30062400_00000004_01072400, // R4 June
    128'h59592303_30122400_00000004_31122400, // R4 December
    128'h59592303_32072400_00000004_33072400  // R8 date above max
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrSel = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic [6:0] secOut, minOut;
  logic [5:0] hourOut, dateOut;
  logic [2:0] dowOut;
  logic [4:0] monthOut;
  logic [7:0] yearOut;
  logic       centOut, centEnOut, prescClr;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #(CLK_HALF) clk = ~clk;

  bcd_calendar #(.RST_YEAR(8'h24), .RST_CENT_EN(1'b1)) i_bcd_calendar (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .secOut(secOut), .minOut(minOut), .hourOut(hourOut),
    .dowOut(dowOut), .dateOut(dateOut), .monthOut(monthOut),
    .yearOut(yearOut), .centOut(centOut), .centEnOut(centEnOut),
    .prescClr(prescClr)
  );

  function automatic logic [63:0] observed();
    return {1'b0, secOut, 1'b0, minOut, 2'b0, hourOut, 5'b0, dowOut,
            2'b0, dateOut, 3'b0, monthOut, yearOut,
            6'b0, centEnOut, centOut};
  endfunction

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called and returning at a falling edge
  task automatic writeField(input logic [2:0] sel, input logic [7:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tickOnce();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic loadAll(input logic [63:0] s);
    for (int f = 0; f < 8; f++) writeField(3'(f), s[63 - 8*f -: 8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", observed(), 64'h00000001_01012402);
    check("R1 presc", {63'b0, prescClr}, 64'd0);

    // R11 idle cycles change nothing
    repeat (5) @(negedge clk);
    check("R11", observed(), 64'h00000001_01012402);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      loadAll(VEC[v][127:64]);
      tickOnce();
      check($sformatf("vec%0d", v), observed(), VEC[v][63:0]);
    end

    // R10 prescaler pulse timing
    wrEn = 1'b1; wrSel = 3'd0; wrData = 8'h59;
    @(negedge clk);
    wrEn = 1'b0;
    check("R10 pulse", {63'b0, prescClr}, 64'd1);
    @(negedge clk);
    check("R10 single", {63'b0, prescClr}, 64'd0);

    // R9 write plus tick in the same cycle: tick dropped
    writeField(3'd1, 8'h10);
    tick = 1'b1; wrEn = 1'b1; wrSel = 3'd1; wrData = 8'h20;
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0;
    check("R9 sec held", {57'b0, secOut}, 64'h59);
    check("R9 min loaded", {57'b0, minOut}, 64'h20);
    tickOnce();
    check("R9 after", {50'b0, secOut, minOut}, {50'b0, 7'h00, 7'h21});

    // R12 upper write bits ignored
    writeField(3'd2, 8'hFF);
    check("R12 hour", {58'b0, hourOut}, 64'h3F);
    writeField(3'd0, 8'hFF);
    check("R12 sec", {57'b0, secOut}, 64'h7F);

    // R8 seconds 7F: units >= 9 and above max, wraps with carry
    tickOnce();
    check("R8 wrap", {50'b0, secOut, minOut}, {50'b0, 7'h00, 7'h22});

    // R11 hold after activity
    repeat (4) @(negedge clk);
    check("R11 hold", {50'b0, secOut, minOut}, {50'b0, 7'h00, 7'h22});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule